// File: doc/BRIEF.md
# Multi-Format Line Encoder

This block turns a serial bit stream into a baseband line code that can be chosen while the block runs. The surrounding logic provides a half-bit strobe at twice the bit rate. It also provides a bit-rate strobe that is raised together with the half-bit strobe at the start of each bit. Every half-bit strobe yields one tri-level symbol on a registered two-bit output. The symbol is positive, zero or negative.

Five codes are available: level NRZ, inverting NRZ, three-level return-to-zero, Manchester and differential Manchester. The data bit and the format are sampled only at a bit start. A format change asked for in the middle of a bit therefore waits for the next bit boundary. The inverting NRZ code and the differential Manchester code each keep a line-level history from bit to bit. Each history is kept separately and is preserved while other codes are in use.

Top module: `line_encoder`

## Requirements
- R1: After reset the output symbol is zero (2'b00), and both history levels (inverting NRZ and differential Manchester) are positive.
- R2: A bit start is a cycle with both `half_en` and `bit_en` high. A mid-bit point is a cycle with `half_en` high and `bit_en` low. The output takes its new symbol one clock after `half_en` and holds it in all other cycles. `bit_en` without `half_en` has no effect.
- R3: `data_in` and `fmt_sel` are sampled only at a bit start. Changing them at a mid-bit point does not affect the symbol of that bit. Format codes: 0 level NRZ, 1 inverting NRZ, 2 return-to-zero, 3 Manchester, 4 differential Manchester. Codes 5 to 7 behave as code 0.
- R4: Level NRZ sends positive for a 0 bit and negative for a 1 bit, in both halves.
- R5: Inverting NRZ flips the held level at the start of a 1 bit and keeps it for a 0 bit. The same level is sent in both halves.
- R6: Return-to-zero sends positive (bit 1) or negative (bit 0) in the first half and zero in the second half.
- R7: Manchester sends a 1 as negative then positive and a 0 as positive then negative.
- R8: Differential Manchester always inverts at mid-bit. A 0 bit also inverts at the bit start relative to the previous level. A 1 bit does not.
- R9: Symbols are coded 2'b01 positive, 2'b00 zero, 2'b11 negative. 2'b10 never appears.
- R10: The history level of each code changes only while that code is the active format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_en | input | 1 | Half-bit strobe, twice the bit rate |
| bit_en | input | 1 | Bit-start strobe, valid together with half_en |
| data_in | input | 1 | Serial data bit |
| fmt_sel | input | 3 | Line code select |
| sym_out | output | 2 | Tri-level output symbol |

## Verification
A wrong history level for inverting NRZ or differential Manchester inverts every later symbol of that code. This shows up at the first symbol of the next bit that uses the code. It is not limited to the bit where the fault started. A wrong latched format or bit shows at the mid-bit symbol one clock after the mid-bit strobe. Random mid-bit changes of the format and the data make such a fault visible within one bit. Switching formats at random between bits exposes histories that change while their code is not active.

// File: rtl/le_pkg.sv
package le_pkg;
  localparam int FMT_W = 3;
  localparam int SYM_W = 2;
  localparam int NUM_HIST = 2;
  localparam int HIST_NRZI = 0;
  localparam int HIST_DMAN = 1;

  localparam logic [SYM_W-1:0] SYM_POS  = 2'b01;
  localparam logic [SYM_W-1:0] SYM_ZERO = 2'b00;
  localparam logic [SYM_W-1:0] SYM_NEG  = 2'b11;

  typedef enum logic [FMT_W-1:0] {
    FMT_NRZL = 3'd0,
    FMT_NRZI = 3'd1,
    FMT_RZ   = 3'd2,
    FMT_MAN  = 3'd3,
    FMT_DMAN = 3'd4
  } fmt_e;

  function automatic fmt_e fmt_decode(input logic [FMT_W-1:0] code);
    case (code)
      3'd1:    return FMT_NRZI;
      3'd2:    return FMT_RZ;
      3'd3:    return FMT_MAN;
      3'd4:    return FMT_DMAN;
      default: return FMT_NRZL;
    endcase
  endfunction

  function automatic logic [SYM_W-1:0] level_sym(input logic pos);
    return pos ? SYM_POS : SYM_NEG;
  endfunction
endpackage

// File: rtl/le_bit_capture.sv
module le_bit_capture
  import le_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             data_in,
  input  logic [FMT_W-1:0] fmt_in,
  output logic             cur_bit,
  output fmt_e             cur_fmt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_bit <= 1'b0;
      cur_fmt <= FMT_NRZL;
    end else if (start) begin
      cur_bit <= data_in;
      cur_fmt <= fmt_decode(fmt_in);
    end
  end
endmodule

// File: rtl/le_history.sv
module le_history
  import le_pkg::*;
#(
  parameter int N = NUM_HIST
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] upd,
  input  logic [N-1:0] nxt,
  output logic [N-1:0] lvl
);
  for (genvar i = 0; i < N; i++) begin : g_hist
    always_ff @(posedge clk) begin
      if (rst)         lvl[i] <= 1'b1;
      else if (upd[i]) lvl[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/le_symbol_map.sv
module le_symbol_map
  import le_pkg::*;
(
  input  logic             start,
  input  logic             bit_val,
  input  fmt_e             fmt,
  input  logic [NUM_HIST-1:0] hist,
  output logic [SYM_W-1:0] sym,
  output logic [NUM_HIST-1:0] upd,
  output logic [NUM_HIST-1:0] nxt
);
  logic nrzi_next, dman_next;

  always_comb begin
    nrzi_next = (start && bit_val) ? ~hist[HIST_NRZI] : hist[HIST_NRZI];
    if (start) dman_next = bit_val ? hist[HIST_DMAN] : ~hist[HIST_DMAN];
    else       dman_next = ~hist[HIST_DMAN];

    upd = '0;
    nxt = hist;
    nxt[HIST_NRZI] = nrzi_next;
    nxt[HIST_DMAN] = dman_next;

    case (fmt)
      FMT_NRZI: begin
        sym = level_sym(nrzi_next);
        upd[HIST_NRZI] = 1'b1;
      end
      FMT_RZ:   sym = start ? level_sym(~bit_val) == SYM_POS ? SYM_NEG : SYM_POS
                            : SYM_ZERO;
      FMT_MAN:  sym = start ? level_sym(~bit_val) : level_sym(bit_val);
      FMT_DMAN: begin
        sym = level_sym(dman_next);
        upd[HIST_DMAN] = 1'b1;
      end
      default:  sym = level_sym(~bit_val);
    endcase
  end
endmodule

// File: rtl/line_encoder.sv
module line_encoder
  import le_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             half_en,
  input  logic             bit_en,
  input  logic             data_in,
  input  logic [2:0]       fmt_sel,
  output logic [1:0]       sym_out
);
  logic start;
  logic cur_bit;
  fmt_e cur_fmt;
  logic eff_bit;
  fmt_e eff_fmt;
  logic [NUM_HIST-1:0] hist_lvl, map_upd, map_nxt;
  logic [SYM_W-1:0] map_sym;

  assign start   = half_en & bit_en;
  assign eff_bit = start ? data_in : cur_bit;
  assign eff_fmt = start ? fmt_decode(fmt_sel) : cur_fmt;

  le_bit_capture u_cap (
    .clk(clk), .rst(rst), .start(start), .data_in(data_in),
    .fmt_in(fmt_sel), .cur_bit(cur_bit), .cur_fmt(cur_fmt)
  );

  le_symbol_map u_map (
    .start(start), .bit_val(eff_bit), .fmt(eff_fmt), .hist(hist_lvl),
    .sym(map_sym), .upd(map_upd), .nxt(map_nxt)
  );

  le_history #(.N(NUM_HIST)) u_hist (
    .clk(clk), .rst(rst), .upd(map_upd & {NUM_HIST{half_en}}),
    .nxt(map_nxt), .lvl(hist_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst)          sym_out <= SYM_ZERO;
    else if (half_en) sym_out <= map_sym;
  end
endmodule

// File: rtl/le_chk.sv
module le_chk (
  input logic       clk,
  input logic       rst,
  input logic       half_en,
  input logic       bit_en,
  input logic [1:0] sym_out,
  input logic [2:0] cur_fmt
);
  // R9
  sym_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    sym_out != 2'b10);

  // R2
  sym_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !half_en |=> $stable(sym_out));

  // R6
  rz_mid_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (half_en && !bit_en && cur_fmt == 3'd2) |=> sym_out == 2'b00);

  // R7
  biphase_mid_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (half_en && !bit_en && (cur_fmt == 3'd3 || cur_fmt == 3'd4))
      |=> (sym_out != $past(sym_out)) && (sym_out != 2'b00));

  // R4
  nrzl_mid_same_chk: assert property (@(posedge clk) disable iff (rst)
    (half_en && !bit_en && cur_fmt == 3'd0 && sym_out != 2'b00)
      |=> $stable(sym_out));
endmodule

bind line_encoder le_chk u_chk (
  .clk(clk), .rst(rst), .half_en(half_en), .bit_en(bit_en),
  .sym_out(sym_out), .cur_fmt(cur_fmt)
);

// File: tb/tb_line_encoder.sv
module tb_line_encoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] POS = 2'b01, ZER = 2'b00, NEG = 2'b11;

  logic clk = 1'b0, rst = 1'b1, half_en = 1'b0, bit_en = 1'b0, data_in = 1'b0;
  logic [2:0] fmt_sel = 3'd0;
  logic [1:0] sym_out;

  int checks = 0, errors = 0;
  logic m_nrzi = 1'b1, m_dm = 1'b1, m_bit = 1'b0;
  int m_fmt = 0;

  line_encoder dut (.clk(clk), .rst(rst), .half_en(half_en), .bit_en(bit_en),
                    .data_in(data_in), .fmt_sel(fmt_sel), .sym_out(sym_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [1:0] lv(input logic p);
    return p ? POS : NEG;
  endfunction

  function automatic string req_of(input int f);
    case (f)
      1: return "R5"; 2: return "R6"; 3: return "R7"; 4: return "R8";
      default: return "R4";
    endcase
  endfunction

  // Model from R3..R8: returns expected symbol, updates model state.
  function automatic logic [1:0] model(input logic start);
    case (m_fmt)
      1: begin if (start && m_bit) m_nrzi = ~m_nrzi; return lv(m_nrzi); end
      2: return start ? (m_bit ? POS : NEG) : ZER;
      3: return start ? (m_bit ? NEG : POS) : (m_bit ? POS : NEG);
      4: begin
           if (!start || !m_bit) m_dm = ~m_dm;
           return lv(m_dm);
         end
      default: return m_bit ? NEG : POS;
    endcase
  endfunction

  task automatic chk(input string req, input logic [1:0] exp);
    checks++;
    if (sym_out !== exp) begin
      errors++;
      $display("FAIL %s: sym_out=%b expected=%b", req, sym_out, exp);
    end
  endtask

  // One half-bit: drive on negedge, the output updates at the next posedge.
  task automatic half(input logic start, input logic d, input logic [2:0] f,
                      input int idle);
    logic [1:0] e;
    @(negedge clk);
    half_en = 1'b1; bit_en = start; data_in = d; fmt_sel = f;
    if (start) begin
      m_bit = d;
      m_fmt = (f > 3'd4) ? 0 : int'(f);
    end
    e = model(start);
    @(negedge clk);
    half_en = 1'b0; bit_en = 1'b0;
    chk(req_of(m_fmt), e);
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      if (i == idle - 1) chk("R2", e);
    end
  endtask

  task automatic send_bit(input logic d, input logic [2:0] f, input int idle);
    half(1'b1, d, f, idle);
    // R3: scramble format and data at mid-bit
    half(1'b0, ~d, 3'($urandom_range(0, 7)), idle);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", ZER);

    // R2: bit_en alone has no effect
    bit_en = 1'b1; data_in = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    @(negedge clk);
    chk("R2", ZER);

    // R1/R5: history starts positive, first 1 gives negative
    send_bit(1'b1, 3'd1, 1);
    send_bit(1'b0, 3'd1, 0);
    // R1/R8: first 0 in differential Manchester starts negative
    send_bit(1'b0, 3'd4, 0);
    send_bit(1'b1, 3'd4, 0);
    // R10: other formats in between leave histories alone
    send_bit(1'b1, 3'd3, 0);
    send_bit(1'b0, 3'd2, 0);
    send_bit(1'b1, 3'd6, 0);
    send_bit(1'b1, 3'd1, 0);
    send_bit(1'b1, 3'd4, 0);
    send_bit(1'b0, 3'd0, 2);

    // Random mix of formats and data
    for (int n = 0; n < 600; n++)
      send_bit(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
               $urandom_range(0, 2));

    // R1: reset returns output to zero and histories to positive
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; m_nrzi = 1'b1; m_dm = 1'b1;
    @(negedge clk);
    chk("R1", ZER);
    send_bit(1'b0, 3'd4, 0);
    send_bit(1'b1, 3'd1, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule